// File: doc/BRIEF.md
# Colour LCD Controller Register Slave

This block is the programming face of a colour LCD controller. It is an APB-style slave that decodes a 4 KiB address window. It holds four timing words, two frame base addresses (upper and lower panel), an interrupt mask, a control word and a raw interrupt status with a write-one-to-clear port. A fixed identification area and a window onto external palette storage sit in the same window.

From the packed timing words the block derives the active pixels per line and the active line count. It presents these to the display pipeline together with a combined enable and the pixel-depth code. Interrupt events from the pipeline set bits in the raw status. The interrupt output is the OR of the raw bits that are enabled in the mask.

A board strap selects a variant in which the addresses of the mask and control words are exchanged.

Top module: `lcd_regif`

## Requirements
- R1: After reset every register reads zero, `lcd_enable` and `irq` are low, `active_w` is 16 and `active_h` is 1.
- R2: Word offsets 0 to 5 (byte 0x00 to 0x14) are read/write registers: the four timing words, then the upper and the lower frame base. Each reads back the last value written to it.
- R3: `active_w` equals ((timing0 AND 0xFC) + 4) * 4, and `active_h` equals timing1[9:0] + 1.
- R4: Control bit 1 through bit 3 drive `pix_depth`. `lcd_enable` is high only while control bit 0 and control bit 11 are both set.
- R5: With `variant` low, word offset 6 is the mask and offset 7 is control. With `variant` high, the two offsets swap roles for both reads and writes.
- R6: A high bit on `irq_set` sets the matching raw status bit. Offset 8 reads the raw status, and offset 9 reads the raw status ANDed with the mask. `irq` is high when any masked bit is set.
- R7: A write to offset 10 clears each raw bit that is 1 in the written data. When an event for a bit arrives in the same cycle as its clear, the bit ends up set.
- R8: Offsets 11 and 12 read back the upper and the lower frame base.
- R9: Byte addresses 0xFE0 to 0xFFC return, one per word, the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: An access from 0x200 to 0x3FC raises `pal_sel` with `pal_addr` = (paddr - 0x200) / 4, raises `pal_we` on writes, passes `pwdata` through, and returns `pal_rdata` on reads.
- R11: An access to any offset not listed above raises `pslverr`, reads zero and changes no register. A write to a read-only offset (8, 9, 11, 12 or the identification area) is ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant | input | 1 | Board strap that swaps the mask and control offsets |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response for an unmapped offset |
| irq_set | input | IRQ_W | Interrupt event pulses |
| irq | output | 1 | Combined masked interrupt |
| pal_sel | output | 1 | Palette access strobe |
| pal_we | output | 1 | Palette write strobe |
| pal_addr | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| lcd_enable | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel-depth code |
| active_w | output | 11 | Active pixels per line |
| active_h | output | 11 | Active lines |

## Verification
An interrupt event and a software clear of the same status bit can land on the same clock edge. The bench provokes this by driving `irq_set` during the access phase of a clear write that names that bit and other bits. The bits that were named only by the clear must read back as zero. The bit that also had an event must read back as set, and `irq` must stay high through the masked path.

// File: rtl/lcd_regif.sv
module lcd_regif #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             variant,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             pslverr,
  input  logic [IRQ_W-1:0] irq_set,
  output logic             irq,
  output logic             pal_sel,
  output logic             pal_we,
  output logic [6:0]       pal_addr,
  output logic [31:0]      pal_wdata,
  input  logic [31:0]      pal_rdata,
  output logic             lcd_enable,
  output logic [2:0]       pix_depth,
  output logic [10:0]      active_w,
  output logic [10:0]      active_h
);
  localparam int PADW = 32 - IRQ_W;

  logic [31:0] tim_q [4];
  logic [31:0] upb_q, lpb_q, ctrl_q;
  logic [IRQ_W-1:0] mask_q, raw_q;

  logic       acc, wr;
  logic [9:0] widx;
  logic       in_pal, in_id, in_reg, sel_mask, sel_ctrl;
  logic       unused_ok;

  assign acc    = psel & penable;
  assign wr     = acc & pwrite;
  assign widx   = paddr[11:2];
  assign in_pal = paddr[11:9] == 3'b001;
  assign in_id  = paddr[11:5] == 7'h7F;
  assign in_reg = widx <= 10'd12;

  assign sel_mask = variant ? (widx == 10'd7) : (widx == 10'd6);
  assign sel_ctrl = variant ? (widx == 10'd6) : (widx == 10'd7);

  assign pal_sel   = acc & in_pal;
  assign pal_we    = pal_sel & pwrite;
  assign pal_addr  = paddr[8:2];
  assign pal_wdata = pwdata;

  assign pslverr = acc & ~(in_pal | in_id | in_reg);

  assign lcd_enable = ctrl_q[0] & ctrl_q[11];
  assign pix_depth  = ctrl_q[3:1];
  assign active_w   = {({1'b0, tim_q[0][7:2]} + 7'd1), 4'b0000};
  assign active_h   = {1'b0, tim_q[1][9:0]} + 11'd1;
  assign irq        = |(raw_q & mask_q);

  assign unused_ok = &{1'b0, paddr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr && in_reg) begin
      if (widx < 10'd4) tim_q[widx[1:0]] <= pwdata;
      if (widx == 10'd4) upb_q <= pwdata;
      if (widx == 10'd5) lpb_q <= pwdata;
      if (sel_mask) mask_q <= pwdata[IRQ_W-1:0];
      if (sel_ctrl) ctrl_q <= pwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else if (wr && widx == 10'd10) raw_q <= (raw_q & ~pwdata[IRQ_W-1:0]) | irq_set;
    else raw_q <= raw_q | irq_set;
  end

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    if (acc && !pwrite) begin
      if (in_pal) prdata = pal_rdata;
      else if (in_id) prdata = {24'd0, id_byte(paddr[4:2])};
      else if (sel_mask) prdata = {{PADW{1'b0}}, mask_q};
      else if (sel_ctrl) prdata = ctrl_q;
      else begin
        case (widx)
          10'd0, 10'd1, 10'd2, 10'd3: prdata = tim_q[widx[1:0]];
          10'd4, 10'd11: prdata = upb_q;
          10'd5, 10'd12: prdata = lpb_q;
          10'd8:  prdata = {{PADW{1'b0}}, raw_q};
          10'd9:  prdata = {{PADW{1'b0}}, raw_q & mask_q};
          default: prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [31:0]      prdata,
  input logic             pslverr,
  input logic [IRQ_W-1:0] irq_set,
  input logic [IRQ_W-1:0] raw,
  input logic [IRQ_W-1:0] mask,
  input logic             irq,
  input logic             pal_sel,
  input logic             pal_we,
  input logic             lcd_enable,
  input logic [10:0]      active_w,
  input logic [10:0]      active_h
);
  // R4
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_enable) |-> $past(psel && penable && pwrite));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((raw & $past(irq_set)) == $past(irq_set)));
  // R6
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && raw != '0));
  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == 32'd0 && psel && penable && !pal_sel));
  // R10
  pal_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (pal_sel && pwrite));
  // R3
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> ($stable(active_w) && $stable(active_h)));
endmodule

bind lcd_regif lcd_regif_chk #(.IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .prdata(prdata), .pslverr(pslverr), .irq_set(irq_set), .raw(raw_q),
  .mask(mask_q), .irq(irq), .pal_sel(pal_sel), .pal_we(pal_we),
  .lcd_enable(lcd_enable), .active_w(active_w), .active_h(active_h)
);

// File: tb/lcd_regif_tb_top.sv
module lcd_regif_tb_top;
  logic        clk = 0, rst_n = 0, variant = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pslverr, irq, pal_sel, pal_we, lcd_enable;
  logic [3:0]  irq_set = '0;
  logic [6:0]  pal_addr;
  logic [31:0] pal_wdata, pal_rdata;
  logic [2:0]  pix_depth;
  logic [10:0] active_w, active_h;
  logic [31:0] pal_mem [128];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_regif dut_i (.*);

  assign pal_rdata = pal_mem[pal_addr];
  always_ff @(posedge clk) if (pal_we) pal_mem[pal_addr] <= pal_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; irq_set = ev;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; irq_set = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_ev(a, d, 4'd0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1; d = prdata; e = pslverr;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(req, d, exp);
    chk({req, " err"}, {31'd0, e}, 32'd0);
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); irq_set = v;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic t_reset;
    chk("R1 enable", {31'd0, lcd_enable}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 width", {21'd0, active_w}, 16);
    chk("R1 height", {21'd0, active_h}, 1);
    for (int i = 0; i <= 12; i++) if (i != 10) rd_chk("R1 reg", 12'(i * 4), 0);
  endtask

  task automatic t_rw;
    for (int i = 0; i < 6; i++) wr(12'(i * 4), 32'hA500_0000 + 32'(i * 32'h111));
    for (int i = 0; i < 6; i++) rd_chk("R2 readback", 12'(i * 4), 32'hA500_0000 + 32'(i * 32'h111));
    rd_chk("R8 upper current", 12'h02C, 32'hA500_0444);
    rd_chk("R8 lower current", 12'h030, 32'hA500_0555);
  endtask

  task automatic t_size;
    wr(12'h000, 32'h0000_00FF); chk("R3 width max", {21'd0, active_w}, 1024);
    wr(12'h000, 32'hFFFF_FF13); chk("R3 width 80", {21'd0, active_w}, 80);
    wr(12'h004, 32'h0000_03FF); chk("R3 height max", {21'd0, active_h}, 1024);
    wr(12'h004, 32'hFFFF_FDDF); chk("R3 height 480", {21'd0, active_h}, 480);
    wr(12'h004, 32'hFFFF_FC00); chk("R3 height min", {21'd0, active_h}, 1);
  endtask

  task automatic t_enable;
    wr(12'h01C, 32'h001); chk("R4 en only", {31'd0, lcd_enable}, 0);
    wr(12'h01C, 32'h800); chk("R4 pwr only", {31'd0, lcd_enable}, 0);
    wr(12'h01C, 32'h80B); chk("R4 both", {31'd0, lcd_enable}, 1);
    chk("R4 depth", {29'd0, pix_depth}, 5);
    wr(12'h01C, 32'h000); chk("R4 off", {31'd0, lcd_enable}, 0);
  endtask

  task automatic t_variant;
    variant = 1;
    wr(12'h018, 32'h801); chk("R5 swapped ctrl", {31'd0, lcd_enable}, 1);
    wr(12'h01C, 32'h3);
    rd_chk("R5 offset6 ctrl", 12'h018, 32'h801);
    rd_chk("R5 offset7 mask", 12'h01C, 32'h3);
    variant = 0;
    rd_chk("R5 normal mask", 12'h018, 32'h3);
    rd_chk("R5 normal ctrl", 12'h01C, 32'h801);
    wr(12'h01C, 32'h0); wr(12'h018, 32'h0);
  endtask

  task automatic t_irq;
    pulse(4'b0101);
    chk("R6 irq masked off", {31'd0, irq}, 0);
    rd_chk("R6 raw", 12'h020, 32'h5);
    wr(12'h018, 32'h4);
    chk("R6 irq on", {31'd0, irq}, 1);
    rd_chk("R6 masked", 12'h024, 32'h4);
    wr(12'h018, 32'h2);
    chk("R6 irq unmasked bit", {31'd0, irq}, 0);
    wr(12'h028, 32'h1);
    rd_chk("R7 clear one", 12'h020, 32'h4);
    wr(12'h018, 32'hF);
    wr_ev(12'h028, 32'hF, 4'b0010);
    rd_chk("R7 set beats clear", 12'h020, 32'h2);
    chk("R7 irq after collision", {31'd0, irq}, 1);
    wr(12'h028, 32'hF);
    chk("R7 irq cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_id;
    logic [7:0] exp [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) rd_chk("R9 id", 12'hFE0 + 12'(i * 4), {24'd0, exp[i]});
  endtask

  task automatic t_pal;
    wr(12'h200, 32'h1234_5678);
    wr(12'h3FC, 32'hCAFE_0001);
    chk("R10 write low", pal_mem[0], 32'h1234_5678);
    chk("R10 write high", pal_mem[127], 32'hCAFE_0001);
    pal_mem[5] = 32'h0BAD_F00D;
    rd_chk("R10 read", 12'h214, 32'h0BAD_F00D);
    rd_chk("R10 read high", 12'h3FC, 32'hCAFE_0001);
  endtask

  task automatic t_err;
    logic [31:0] d; logic e;
    wr(12'h01C, 32'h801);
    rd(12'h034, d, e);
    chk("R11 err flag", {31'd0, e}, 1); chk("R11 err data", d, 0);
    rd(12'h400, d, e);
    chk("R11 err flag hole", {31'd0, e}, 1); chk("R11 err data hole", d, 0);
    wr(12'h800, 32'h0);
    rd_chk("R11 ctrl unchanged", 12'h01C, 32'h801);
    chk("R11 enable kept", {31'd0, lcd_enable}, 1);
    pulse(4'b1000);
    wr(12'h020, 32'h0); wr(12'h02C, 32'h0);
    rd_chk("R11 raw ignores write", 12'h020, 32'h8);
    rd_chk("R11 current ignores write", 12'h02C, 32'hA500_0444);
    wr(12'hFE0, 32'hFF);
    rd_chk("R11 id ignores write", 12'hFE0, 32'h10);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) pal_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_rw; t_size; t_enable; t_variant; t_irq; t_id; t_pal; t_err;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule